// File: doc/BRIEF.md
# Protection Entry Configuration Register with Write Legalization

This block is a machine-mode control/status register that holds the configuration bytes of eight memory-protection entries. The entries are numbered from 32 to 39, and byte slot k, in bits 8k+7:8k, belongs to entry 32+k. Software writes the whole register through a simple CSR port. Before a byte is stored, the block checks that byte on its own. If the stored entry is locked, or if the new byte carries an encoding the configuration does not allow, the write to that byte is dropped and the old value stays. The block never repairs a rejected byte; it keeps the old byte whole.

Two parameters shape the register. `IMPL_ENTRIES` is the number of implemented protection entries. A slot whose entry number is not below that count is read-only and reads as zero. `GRAIN` is the region granularity exponent. When it is 2 or more, the four-byte region mode cannot be used.

A width input selects between two views of the register. In the 32-bit view only slots 0 to 3 are visible and writable. In the 64-bit view all eight slots are. Every slot's lock flag, address mode and permissions are also driven out in decoded form, so that the protection checker can apply locked entries to machine-mode accesses.

Top module: `pmp_hi_cfg_csr`

## Requirements
- R1: After reset every slot reads as zero, so every entry is unlocked, mode OFF, with no permissions, and all decoded outputs are zero.
- R2: A write with `csr_we_i` high and `csr_addr_i` equal to 12'h3A8 updates the legal bytes at the next rising clock edge. Byte k holds: bit 7 lock, bits 4:3 address mode (0 OFF, 1 TOR, 2 four-byte region, 3 power-of-two region), bit 2 execute, bit 1 write, bit 0 read. A write to any other address changes nothing, and a read of any other address returns zero.
- R3: Bits 6:5 of every byte always read as zero. Writes to them have no effect.
- R4: Once the stored lock bit (bit 7) of a slot is set, writes to that slot are discarded. Only reset clears the lock.
- R5: A written byte with read (bit 0) clear and write (bit 1) set is discarded as a whole, and the old byte is kept.
- R6: When `GRAIN` is 2 or more, a written byte with address mode 2 is discarded as a whole, and the old byte is kept.
- R7: Each byte of a write is accepted or rejected on its own. A rejected byte does not stop the other bytes of the same write from updating.
- R8: A slot k with 32+k not below `IMPL_ENTRIES` always reads as zero and ignores writes. With the default of 38, slots 6 and 7 are such slots.
- R9: With `wide_mode_i` low, `csr_rdata_o[63:32]` reads as zero and a write leaves slots 4 to 7 unchanged. Those slots become visible again when `wide_mode_i` is high.
- R10: For each slot k, the decoded outputs carry the stored byte: `entry_lock_o[k]` is bit 7, `entry_mode_o[2k+1:2k]` is bits 4:3, and `entry_perm_o[3k+2:3k]` is bits 2:0 (execute, write, read).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| csr_addr_i | input | 12 | CSR address for both the read and the write |
| csr_we_i | input | 1 | Write strobe |
| csr_wdata_i | input | 64 | Write data, byte k for slot k |
| wide_mode_i | input | 1 | 1 selects the 64-bit view, 0 the 32-bit view |
| csr_rdata_o | output | 64 | Read data (combinational) |
| entry_lock_o | output | 8 | Lock flag for each slot |
| entry_mode_o | output | 16 | Address mode for each slot, 2 bits per slot |
| entry_perm_o | output | 24 | Execute, write and read permissions, 3 bits per slot |

## Verification
The read data is combinational from the address and the stored bytes. A write therefore shows up on `csr_rdata_o` and on the decoded outputs one clock edge after the strobe is sampled, and a rejected byte shows no change at that same point. The bench drives each write on a falling edge and removes the strobe on the next falling edge. It then compares the read port and the decoded outputs there, half a cycle after the update edge and with no write pending. Lock, reserved-encoding and unimplemented-slot results are also checked on every cycle by the bound properties.

// File: rtl/pmp_cfg_pkg.sv
package pmp_cfg_pkg;

  typedef enum logic [1:0] {
    AM_OFF   = 2'd0,
    AM_TOR   = 2'd1,
    AM_NA4   = 2'd2,
    AM_NAPOT = 2'd3
  } amode_e;

  typedef struct packed {
    logic       lock;
    logic [1:0] rsvd;
    amode_e     mode;
    logic       x;
    logic       w;
    logic       r;
  } cfg_byte_t;

  localparam int unsigned CFG_BITS = $bits(cfg_byte_t);

endpackage

// File: rtl/pmp_cfg_legalize.sv
// Decides whether one new configuration byte may replace the stored one.
module pmp_cfg_legalize
  import pmp_cfg_pkg::*;
#(
  parameter int unsigned GRAIN = 2
) (
  input  logic      old_lock_i,
  input  cfg_byte_t new_i,
  output logic      accept_o,
  output cfg_byte_t clean_o
);

  localparam bit NoFourByte = (GRAIN >= 2);

  logic bad_perm;
  logic bad_mode;
  logic unused_rsvd;

  assign bad_perm    = new_i.w & ~new_i.r;
  assign bad_mode    = NoFourByte & (new_i.mode == AM_NA4);
  assign accept_o    = ~old_lock_i & ~bad_perm & ~bad_mode;
  assign unused_rsvd = ^new_i.rsvd;

  always_comb begin
    clean_o      = '0;
    clean_o.lock = new_i.lock;
    clean_o.mode = new_i.mode;
    clean_o.x    = new_i.x;
    clean_o.w    = new_i.w;
    clean_o.r    = new_i.r;
  end

endmodule

// File: rtl/pmp_cfg_slot.sv
// One configuration byte: legalized storage, or constant zero when absent.
module pmp_cfg_slot
  import pmp_cfg_pkg::*;
#(
  parameter bit          PRESENT = 1'b1,
  parameter int unsigned GRAIN   = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wr_en_i,
  input  cfg_byte_t wdata_i,
  output cfg_byte_t q_o
);

  generate
    if (PRESENT) begin : g_store
      cfg_byte_t q_r;
      cfg_byte_t d_n;
      cfg_byte_t clean;
      logic      accept;
      logic      load_en;

      pmp_cfg_legalize #(.GRAIN(GRAIN)) u_legal (
        .old_lock_i (q_r.lock),
        .new_i      (wdata_i),
        .accept_o   (accept),
        .clean_o    (clean)
      );

      assign load_en = wr_en_i & accept;

      always_comb begin
        d_n = q_r;
        if (load_en) d_n = clean;
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      q_r <= '0;
        else if (load_en) q_r <= d_n;
      end

      assign q_o = q_r;
    end else begin : g_absent
      logic unused_in;
      assign unused_in = ^{clk_i, rst_ni, wr_en_i, wdata_i};
      assign q_o       = '0;
    end
  endgenerate

endmodule

// File: rtl/pmp_hi_cfg_csr.sv
module pmp_hi_cfg_csr
  import pmp_cfg_pkg::*;
#(
  parameter int unsigned SLOTS        = 8,
  parameter int unsigned BASE_ENTRY   = 32,
  parameter int unsigned IMPL_ENTRIES = 38,
  parameter int unsigned GRAIN        = 2,
  parameter logic [11:0] CSR_ADDR     = 12'h3A8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [11:0]            csr_addr_i,
  input  logic                   csr_we_i,
  input  logic [SLOTS*8-1:0]     csr_wdata_i,
  input  logic                   wide_mode_i,
  output logic [SLOTS*8-1:0]     csr_rdata_o,
  output logic [SLOTS-1:0]       entry_lock_o,
  output logic [SLOTS*2-1:0]     entry_mode_o,
  output logic [SLOTS*3-1:0]     entry_perm_o
);

  localparam int unsigned DW       = SLOTS * CFG_BITS;
  localparam int unsigned NARROW_N = SLOTS / 2;
  localparam int unsigned NARROW_W = NARROW_N * CFG_BITS;

  logic             addr_hit;
  logic             wr_hit;
  logic [DW-1:0]    full_q;
  cfg_byte_t        slot_q [SLOTS];

  assign addr_hit = (csr_addr_i == CSR_ADDR);
  assign wr_hit   = addr_hit & csr_we_i;

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    localparam bit PRESENT  = ((BASE_ENTRY + k) < IMPL_ENTRIES);
    localparam bit IN_NARROW = (k < NARROW_N);
    logic slot_we;

    assign slot_we = wr_hit & (IN_NARROW | wide_mode_i);

    pmp_cfg_slot #(.PRESENT(PRESENT), .GRAIN(GRAIN)) u_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_en_i (slot_we),
      .wdata_i (cfg_byte_t'(csr_wdata_i[k*CFG_BITS +: CFG_BITS])),
      .q_o     (slot_q[k])
    );

    assign full_q[k*CFG_BITS +: CFG_BITS] = slot_q[k];
    assign entry_lock_o[k]                = slot_q[k].lock;
    assign entry_mode_o[k*2 +: 2]         = slot_q[k].mode;
    assign entry_perm_o[k*3 +: 3]         = {slot_q[k].x, slot_q[k].w, slot_q[k].r};
  end

  always_comb begin
    csr_rdata_o = '0;
    if (addr_hit) begin
      if (wide_mode_i) csr_rdata_o = full_q;
      else             csr_rdata_o[NARROW_W-1:0] = full_q[NARROW_W-1:0];
    end
  end

endmodule

// File: rtl/pmp_hi_cfg_chk.sv
module pmp_hi_cfg_chk #(
  parameter int unsigned SLOTS        = 8,
  parameter int unsigned BASE_ENTRY   = 32,
  parameter int unsigned IMPL_ENTRIES = 38,
  parameter int unsigned GRAIN        = 2,
  parameter logic [11:0] CSR_ADDR     = 12'h3A8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [11:0]          csr_addr_i,
  input logic                 csr_we_i,
  input logic                 wide_mode_i,
  input logic [SLOTS*8-1:0]   csr_rdata_o,
  input logic [SLOTS-1:0]     entry_lock_o,
  input logic [SLOTS*2-1:0]   entry_mode_o,
  input logic [SLOTS*3-1:0]   entry_perm_o
);

  localparam int unsigned HALF = SLOTS * 4;

  // R2
  idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(csr_we_i && csr_addr_i == CSR_ADDR) |=>
      ($stable(entry_lock_o) && $stable(entry_mode_o) && $stable(entry_perm_o)));

  // R9
  narrow_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wide_mode_i |-> csr_rdata_o[SLOTS*8-1:HALF] == '0);

  for (genvar k = 0; k < SLOTS; k++) begin : g_k
    // R4
    lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      entry_lock_o[k] |=> (entry_lock_o[k] && $stable(entry_mode_o[k*2 +: 2])
                           && $stable(entry_perm_o[k*3 +: 3])));

    // R5
    no_write_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(entry_perm_o[k*3+1] && !entry_perm_o[k*3]));

    // R3
    rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      csr_rdata_o[k*8+5 +: 2] == 2'b00);

    if (GRAIN >= 2) begin : g_grain
      // R6
      no_four_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        entry_mode_o[k*2 +: 2] != 2'd2);
    end

    if ((BASE_ENTRY + k) >= IMPL_ENTRIES) begin : g_absent
      // R8
      absent_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!entry_lock_o[k] && entry_mode_o[k*2 +: 2] == 2'd0
         && entry_perm_o[k*3 +: 3] == 3'd0));
    end
  end

endmodule

bind pmp_hi_cfg_csr pmp_hi_cfg_chk #(
  .SLOTS(SLOTS), .BASE_ENTRY(BASE_ENTRY), .IMPL_ENTRIES(IMPL_ENTRIES),
  .GRAIN(GRAIN), .CSR_ADDR(CSR_ADDR)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .csr_addr_i   (csr_addr_i),
  .csr_we_i     (csr_we_i),
  .wide_mode_i  (wide_mode_i),
  .csr_rdata_o  (csr_rdata_o),
  .entry_lock_o (entry_lock_o),
  .entry_mode_o (entry_mode_o),
  .entry_perm_o (entry_perm_o)
);

// File: tb/pmp_hi_cfg_csr_test.sv
module pmp_hi_cfg_csr_test;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic [11:0] csr_addr_i;
  logic        csr_we_i;
  logic [63:0] csr_wdata_i;
  logic        wide_mode_i;
  logic [63:0] csr_rdata_o;
  logic [7:0]  entry_lock_o;
  logic [15:0] entry_mode_o;
  logic [23:0] entry_perm_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  pmp_hi_cfg_csr uut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .csr_addr_i   (csr_addr_i),
    .csr_we_i     (csr_we_i),
    .csr_wdata_i  (csr_wdata_i),
    .wide_mode_i  (wide_mode_i),
    .csr_rdata_o  (csr_rdata_o),
    .entry_lock_o (entry_lock_o),
    .entry_mode_o (entry_mode_o),
    .entry_perm_o (entry_perm_o)
  );

  // {wide, write data, expected read in the same view}
  localparam logic [128:0] VECS [4] = '{
    {1'b1, 64'h0F1F_0519_131A_6B0F, 64'h0000_0519_0000_0B0F}, // R2 R3 R5 R6 R7 R8
    {1'b1, 64'h55AA_00FF_0718_028D, 64'h0000_009F_0718_0B8D}, // R3 R4 R5 R7 R8
    {1'b1, 64'hFFFF_1C00_0008_1100, 64'h0000_1C9F_0008_0B8D}, // R4 R6 R7 R8
    {1'b0, 64'h1D1D_1D1D_0C01_0309, 64'h0000_0000_0C01_038D}  // R4 R9
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic wide, input logic [63:0] d);
    @(negedge clk);
    csr_addr_i  = a;
    wide_mode_i = wide;
    csr_wdata_i = d;
    csr_we_i    = 1'b1;
    @(negedge clk);
    csr_we_i    = 1'b0;
    csr_addr_i  = 12'h3A8;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    rst_ni      = 1'b0;
    csr_addr_i  = 12'h3A8;
    csr_we_i    = 1'b0;
    csr_wdata_i = '0;
    wide_mode_i = 1'b1;
    do_reset();

    check("R1 read", csr_rdata_o, 64'h0);
    check("R1 outputs", {8'h0, entry_lock_o, entry_mode_o, entry_perm_o}, 64'h0);

    for (int i = 0; i < 4; i++) begin
      wr(12'h3A8, VECS[i][128], VECS[i][127:64]);
      wide_mode_i = VECS[i][128];
      #1;
      check($sformatf("R7 vector %0d", i), csr_rdata_o, VECS[i][63:0]);
    end

    // R9: upper slots kept through the narrow write
    wide_mode_i = 1'b1;
    #1;
    check("R9 wide readback", csr_rdata_o, 64'h0000_1C9F_0C01_038D);

    // R10: decoded outputs
    check("R10 lock", {56'h0, entry_lock_o}, 64'h11);
    check("R10 mode", {48'h0, entry_mode_o}, 64'h0F41);
    check("R10 perm", {40'h0, entry_perm_o}, 64'h02785D);

    // R2: other address ignored and reads zero
    wr(12'h3A9, 1'b1, 64'h0707_0707_0707_0707);
    csr_addr_i = 12'h3A9;
    #1;
    check("R2 other addr read", csr_rdata_o, 64'h0);
    csr_addr_i = 12'h3A8;
    #1;
    check("R2 other addr write", csr_rdata_o, 64'h0000_1C9F_0C01_038D);

    // R8: absent slots stay zero even for legal data
    wr(12'h3A8, 1'b1, 64'h0101_1C9F_0C01_038D);
    check("R8 absent slots", csr_rdata_o, 64'h0000_1C9F_0C01_038D);

    // R4 / R1: reset clears lock, slot 0 writable again
    do_reset();
    check("R1 after reset", csr_rdata_o, 64'h0);
    wr(12'h3A8, 1'b1, 64'h0000_0000_0000_000F);
    check("R4 unlock by reset", csr_rdata_o, 64'h0000_0000_0000_000F);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule